// File: doc/BRIEF.md
# Latency-Configurable Two-Port Memory

This block is a 256-word by 32-bit storage array with one write port and one read port sharing a single clock. Two compile-time integers set how many cycles a write takes to land in the array and how many cycles a read takes to return its data. A read latency of zero gives a combinational read path. A third parameter decides what a read returns when it samples a word in the same cycle that a write to that word lands: the contents before the write, or the value being written.

The intended use is as a drop-in array model whose timing matches a pipelined datapath built around it. The write side carries an enable, an address, a data word and one mask bit, and a word is only updated when enable and mask are both high. The read side carries an enable and an address. The read data output holds its last value through cycles in which no enabled request reaches it.

The write latency sets how far the data is pipelined before it reaches the array. The read path depends on the collision policy. With the old-data policy, the array is sampled in the request cycle and the data is then delayed. With the new-data policy, the address is delayed and the array is sampled one cycle before the output register, with a bypass from the landing write.

Top module: `lat_mem`

## Requirements
- R1: Each of the 256 addresses holds its own 32-bit value. After every address has been written once, reading any address returns the value last written to it.
- R2: For a read latency of N ≥ 1, the data for a read request enabled in cycle t appears on `rd_data` in cycle t+N. For N = 0, `rd_data` reflects `rd_addr` in the same cycle.
- R3: A write accepted in cycle t lands in the array at the clock edge that ends cycle t+WR_LAT−1. A later read that samples the array after that edge returns the new value.
- R4: A write with `wr_en` = 1 and `wr_mask` = 0 leaves the array unchanged.
- R5: While `wr_en` = 0, the values on `wr_addr` and `wr_data` do not change the array. While `rd_en` = 0, the value on `rd_addr` does not change `rd_data`.
- R6: A read that samples the array in the same cycle that a write lands on the same address returns the previous contents when `RUW_NEW` = 0, and returns the written data when `RUW_NEW` = 1.
- R7: When an address is written twice, a later read returns the second value.
- R8: For a read latency of 1 or more, `rd_data` keeps its value in every cycle whose matching request had `rd_en` = 0.
- R9: Take a write to address A in cycle t and a read of A in cycle t+2. With `RUW_NEW` = 0 and WR_LAT ≤ 2, the read returns the new value. With `RUW_NEW` = 1 and WR_LAT ≤ RD_LAT+2, it also returns the new value.
- R10: For a read latency of 1 or more, `rd_data` is 0 while `rst_n` is low and until the first enabled read result arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline control and read output |
| wr_en | input | 1 | Write request enable |
| wr_addr | input | 8 | Write word address |
| wr_data | input | 32 | Write data |
| wr_mask | input | 1 | Write mask; the word is updated only when this and `wr_en` are 1 |
| rd_en | input | 1 | Read request enable |
| rd_addr | input | 8 | Read word address |
| rd_data | output | 32 | Read data, valid RD_LAT cycles after the request |

## Verification
The bench checks sixteen configurations: eight latency pairs, each under both collision policies. Random traffic on a 16-word window makes write landings and read samples meet often. If the bypass or the sampling stage were wrong, the result would be off by exactly one write value in one policy only. If a write pipeline stage were dropped or added, the new data would appear a cycle early or late, and the write-then-read-two-later pattern would return stale data. Three other faults each leave a distinct trace. Letting a masked or disabled write through corrupts a word that is read back later. Clocking the output register on every cycle breaks the hold. Losing the reset value shows up before the first read.

// File: rtl/lat_mem.sv
module lat_mem #(
  parameter int DEPTH   = 256,
  parameter int WIDTH   = 32,
  parameter int RD_LAT  = 1,
  parameter int WR_LAT  = 1,
  parameter bit RUW_NEW = 1'b0,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_mask,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  // DP: data stages after the array sample, AP: address stages before it
  localparam int DP = (RD_LAT == 0) ? 0 : (RUW_NEW ? 1 : RD_LAT);
  localparam int AP = RD_LAT - DP;

  logic [WIDTH-1:0] mem [DEPTH];

  logic             c_vld;
  logic [AW-1:0]    c_addr;
  logic [WIDTH-1:0] c_data;

  logic             s_en;
  logic [AW-1:0]    s_addr;
  logic             s_hit;
  logic [WIDTH-1:0] s_val;

  // ---------------- write path ----------------
  generate
    if (WR_LAT == 1) begin : g_wdirect
      assign c_vld  = wr_en & wr_mask;
      assign c_addr = wr_addr;
      assign c_data = wr_data;

      // R4 and R5: a suppressed write leaves the addressed word unchanged
      assert_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_mask) |=> mem[$past(wr_addr)] === $past(mem[wr_addr]));
    end else begin : g_wpipe
      logic [WR_LAT-2:0] v_q;
      logic [AW-1:0]     a_q [WR_LAT-1];
      logic [WIDTH-1:0]  d_q [WR_LAT-1];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q <= '0;
        end else begin
          v_q[0] <= wr_en & wr_mask;
          for (int i = 1; i < WR_LAT - 1; i++) v_q[i] <= v_q[i-1];
        end
      end

      always_ff @(posedge clk) begin
        a_q[0] <= wr_addr;
        d_q[0] <= wr_data;
        for (int i = 1; i < WR_LAT - 1; i++) begin
          a_q[i] <= a_q[i-1];
          d_q[i] <= d_q[i-1];
        end
      end

      assign c_vld  = v_q[WR_LAT-2];
      assign c_addr = a_q[WR_LAT-2];
      assign c_data = d_q[WR_LAT-2];

      // R4 and R5: a suppressed write never enters the landing pipeline
      assert_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_mask) |=> !v_q[0]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (c_vld) mem[c_addr] <= c_data;
  end

  assert_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    c_vld |=> mem[$past(c_addr)] === $past(c_data));

  // ---------------- read address path ----------------
  generate
    if (AP == 0) begin : g_anone
      assign s_en   = rd_en;
      assign s_addr = rd_addr;
    end else begin : g_apipe
      logic [AP-1:0] ae_q;
      logic [AW-1:0] aa_q [AP];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ae_q <= '0;
        end else begin
          ae_q[0] <= rd_en;
          for (int i = 1; i < AP; i++) ae_q[i] <= ae_q[i-1];
        end
      end

      always_ff @(posedge clk) begin
        aa_q[0] <= rd_addr;
        for (int i = 1; i < AP; i++) aa_q[i] <= aa_q[i-1];
      end

      assign s_en   = ae_q[AP-1];
      assign s_addr = aa_q[AP-1];
    end
  endgenerate

  assign s_hit = c_vld && (c_addr == s_addr);
  assign s_val = (RUW_NEW && s_hit) ? c_data : mem[s_addr];

  // ---------------- read data path ----------------
  generate
    if (DP == 0) begin : g_comb
      assign rd_data = s_val;
    end else begin : g_dpipe
      logic [DP-1:0]    de_q;
      logic [WIDTH-1:0] dd_q [DP];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          de_q <= '0;
          for (int i = 0; i < DP; i++) dd_q[i] <= '0;
        end else begin
          de_q[0] <= s_en;
          if (s_en) dd_q[0] <= s_val;
          for (int i = 1; i < DP; i++) begin
            de_q[i] <= de_q[i-1];
            if (de_q[i-1]) dd_q[i] <= dd_q[i-1];
          end
        end
      end

      assign rd_data = dd_q[DP-1];

      assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !de_q[DP-1] |-> $stable(rd_data));

      assert_rst_R10: assert property (@(posedge clk)
        !rst_n |=> rd_data === '0);

      if (RUW_NEW) begin : g_ruw_new
        assert_ruw_R6: assert property (@(posedge clk) disable iff (!rst_n)
          (s_en && c_vld && s_addr == c_addr) |=> dd_q[0] === $past(c_data));
      end else begin : g_ruw_old
        assert_ruw_R6: assert property (@(posedge clk) disable iff (!rst_n)
          (s_en && c_vld && s_addr == c_addr) |=> dd_q[0] === $past(mem[c_addr]));
      end
    end
  endgenerate

endmodule

// File: tb/sim_lat_mem.sv
`timescale 1ns/1ps

module mem_chk #(
  parameter int RL   = 1,
  parameter int WL   = 1,
  parameter bit NEWP = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic        wr_mask,
  input  logic        rd_en,
  input  logic [7:0]  rd_addr,
  input  int          phase,
  output int          checks,
  output int          fails
);
  logic [31:0] rd_data;

  lat_mem #(.RD_LAT(RL), .WR_LAT(WL), .RUW_NEW(NEWP)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  logic [31:0] sh [256];
  bit          mlast [256];
  bit          junk [256];
  int          wcnt [256];
  int          lastc [256];
  bit          hv [5];
  logic [7:0]  ha [5];
  logic [31:0] hd [5];
  bit          re_h [4];
  logic [7:0]  ra_h [4];
  bit          se_h [4];
  logic [31:0] sv_h [4];
  int          st_h [4];
  logic [31:0] exp_q;
  bit          expv;
  int          etag;
  int          cyc;

  initial begin
    checks = 0; fails = 0; expv = 0; cyc = 0; exp_q = '0; etag = 2;
    for (int a = 0; a < 256; a++) lastc[a] = -100;
  end

  task automatic get_commit(output bit v, output logic [7:0] a, output logic [31:0] d);
    if (WL == 1) begin
      v = wr_en && wr_mask; a = wr_addr; d = wr_data;
    end else begin
      v = hv[WL-1]; a = ha[WL-1]; d = hd[WL-1];
    end
  endtask

  function automatic int tag_of(logic [7:0] a, bit coll);
    if (phase == 3) return 9;               // R9 write, gap, read
    if (coll) return 6;                     // R6 collision policy
    if (mlast[a]) return 4;                 // R4 masked write
    if (junk[a]) return 5;                  // R5 disabled-port junk
    if (cyc - lastc[a] <= WL + 1) return 3; // R3 write landing time
    if (wcnt[a] >= 2) return 7;             // R7 rewritten word
    if (phase == 1) return 1;               // R1 full readback
    return 2;                               // R2 read latency
  endfunction

  task automatic check(logic [31:0] act, logic [31:0] expd, int tag);
    checks++;
    if (act !== expd) begin
      fails++;
      $display("FAIL R%0d (rl=%0d wl=%0d new=%0d) t=%0t: rd_data=%h expected=%h",
               tag, RL, WL, NEWP, $time, act, expd);
    end
  endtask

  always @(posedge clk) begin
    bit cv, se;
    logic [7:0] ca, sa;
    logic [31:0] cd, sv;
    int d;
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) hv[k] = 0;
      for (int k = 0; k < 4; k++) begin re_h[k] = 0; se_h[k] = 0; end
      exp_q = '0; expv = 1; etag = 10; // R10 reset value
    end else begin
      get_commit(cv, ca, cd);
      if (NEWP && RL > 1) begin se = re_h[RL-1]; sa = ra_h[RL-1]; end
      else begin se = rd_en; sa = rd_addr; end
      sv = (NEWP && cv && ca == sa) ? cd : sh[sa];
      for (int k = 3; k > 0; k--) begin
        se_h[k] = se_h[k-1]; sv_h[k] = sv_h[k-1]; st_h[k] = st_h[k-1];
      end
      se_h[0] = se; sv_h[0] = sv; st_h[0] = tag_of(sa, cv && ca == sa);
      d = (NEWP || RL == 0) ? 0 : RL - 1;
      if (se_h[d]) begin exp_q = sv_h[d]; etag = st_h[d]; end
      else etag = 8; // R8 output hold
      if (cv) begin
        sh[ca] = cd; wcnt[ca]++; mlast[ca] = 0; junk[ca] = 0; lastc[ca] = cyc;
      end
      if (wr_en && !wr_mask) mlast[wr_addr] = 1;
      if (!wr_en) junk[wr_addr] = 1;
      for (int k = 4; k > 1; k--) begin hv[k] = hv[k-1]; ha[k] = ha[k-1]; hd[k] = hd[k-1]; end
      hv[1] = wr_en && wr_mask; ha[1] = wr_addr; hd[1] = wr_data;
      for (int k = 3; k > 1; k--) begin re_h[k] = re_h[k-1]; ra_h[k] = ra_h[k-1]; end
      re_h[1] = rd_en; ra_h[1] = rd_addr;
      cyc++;
    end
    if (RL > 0) begin
      #1;
      if (expv) check(rd_data, exp_q, etag);
    end
  end

  always @(negedge clk) begin
    bit cv;
    logic [7:0] ca;
    logic [31:0] cd, e;
    if (RL == 0 && rst_n && phase > 0) begin
      #1;
      if (rd_en) begin
        get_commit(cv, ca, cd);
        e = (NEWP && cv && ca == rd_addr) ? cd : sh[rd_addr];
        check(rd_data, e, tag_of(rd_addr, cv && ca == rd_addr));
      end
    end
  end
endmodule

module sim_lat_mem;
  localparam int NCFG = 16;
  localparam int RLS [8] = '{0, 0, 1, 1, 2, 2, 3, 2};
  localparam int WLS [8] = '{1, 2, 1, 2, 1, 2, 2, 4};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_mask = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  int          phase = 0;
  int          ck [NCFG];
  int          fl [NCFG];
  logic [31:0] seed = 32'h1234_5678;
  bit          done = 0, timed_out = 0;

  always #2.5 clk = ~clk;

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    mem_chk #(.RL(RLS[g % 8]), .WL(WLS[g % 8]), .NEWP(g >= 8)) h (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_mask(wr_mask), .rd_en(rd_en), .rd_addr(rd_addr), .phase(phase),
      .checks(ck[g]), .fails(fl[g])
    );
  end

  function automatic logic [31:0] nxt(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  task automatic step(bit we, logic [7:0] wa, logic [31:0] wd, bit wm, bit re, logic [7:0] ra);
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd; wr_mask = wm; rd_en = re; rd_addr = ra;
  endtask

  task automatic junk_step();
    seed = nxt(seed);
    step(0, seed[7:0], seed, seed[8], 0, seed[23:16]);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1: fill every word, then read all back with junk on the idle write port
    phase = 1;
    for (int a = 0; a < 256; a++) step(1, a[7:0], 32'hA5000000 + a * 32'h00010203, 1, 0, 8'h00);
    repeat (6) junk_step();
    for (int a = 0; a < 256; a++) begin
      seed = nxt(seed);
      step(0, seed[7:0], seed, seed[9], 1, 8'(255 - a));
    end
    repeat (6) junk_step();
    // R2..R8: dense random traffic on a small window
    phase = 2;
    for (int i = 0; i < 4000; i++) begin
      seed = nxt(seed);
      step(seed[1:0] != 0, {4'h0, seed[5:2]}, nxt(seed), seed[8:6] != 0,
           seed[10:9] != 0, {4'h0, seed[14:11]});
    end
    repeat (6) junk_step();
    // R9: write A, one idle cycle, read A
    phase = 3;
    for (int i = 0; i < 32; i++) begin
      step(1, 8'(100 + i), 32'hC0DE0000 + i * 7, 1, 0, 8'h00);
      step(0, 8'h00, 32'h0, 0, 0, 8'h00);
      step(1, 8'(200 + i), 32'h0BAD0000 + i, 1, 1, 8'(100 + i));
      repeat (5) step(0, 8'h00, 32'h0, 0, 0, 8'h00);
    end
    phase = 2;
    repeat (8) junk_step();
    done = 1;
  end

  initial begin
    #(5.0 * 150000);
    timed_out = 1;
  end

  initial begin
    int tot, bad;
    wait (done || timed_out);
    tot = 0; bad = 0;
    for (int g = 0; g < NCFG; g++) begin tot += ck[g]; bad += fl[g]; end
    if (timed_out && !done) begin
      tot++; bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    end
    $display("[TB] %0d tests run, %0d failed", tot, bad);
    $finish;
  end
endmodule